// File: doc/BRIEF.md
# Volume-Scaled Three-Voice PWM Mixer

This block is the output stage of a small three-voice tone synthesizer. Every clock it sees three unsigned 8-bit voice samples. It adds them, scales the sum by a 4-bit master volume, and clips the result to 8 bits. The clipped value becomes the duty of a single-bit pulse-width-modulated output. An external RC low-pass network on that pin recovers the audio.

The master volume sits in a register on the synthesizer's shared parallel write port. The register address is 5 bits wide, formed as the 2-bit voice select above the 3-bit register number. The volume lives at address 0x18. The port also decodes the filter cutoff and resonance addresses, but writes to them are dropped. The mix always goes straight to the modulator with no filter stage.

The modulator counter has a period of 255 clocks, which is about 94.1 kHz at 24 MHz. A new duty value is taken only at the start of each period, so the pulse never changes shape partway through a period.

Top module: `mix_pwm_top`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the output is low, the period counter and latched duty are zero, and the volume is zero. After release, the first period is all low.
- R2: The period counter counts 0, 1, …, 254 and then returns to 0, giving a period of exactly 255 clocks.
- R3: In each period the output is high for exactly those cycles in which the counter is below the latched duty. A period therefore has exactly `duty` high cycles.
- R4: The duty latched for a period equals floor((v0 + v1 + v2) × volume / 15). Voice k occupies bits [8k+7:8k] of the sample bus.
- R5: When the scaled value exceeds 255, the duty is 255 rather than a wrapped value.
- R6: The duty is loaded only on the clock edge where the counter goes from 254 to 0. Voice or volume changes at any other time affect only the following period. A volume write on that same edge is not seen until the period after.
- R7: A write strobe with address 0x18 loads data bits [3:0] into the volume. Data bits [7:4] are ignored.
- R8: Writes to any other address, including the filter addresses 0x15–0x17, leave the volume unchanged.
- R9: A volume of 0 gives an output that stays low for the whole period. A duty of 255 gives an output that stays high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voice_samples | input | 24 | Three unsigned voice samples, voice k at [8k+7:8k] |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 5 | Register address {voice select, register number} |
| reg_wdata | input | 8 | Register write data |
| pwm_out | output | 1 | Pulse-width-modulated audio |

## Verification
A volume write and the period-boundary duty latch can fall on the same clock edge. When they do, the old volume must set the duty for the period that is starting, and the new volume must take effect one period later. The bench follows its own cycle-level model to find the cycle in which the counter reads 254. It drives the write strobe so that the write lands on the wrap edge. It then counts the high cycles over the next two whole periods: the first must reflect the old volume and the second the new one. Sample changes in the middle of a period are judged the same way, by high-cycle counts per period.

// File: rtl/mix_pkg.sv
package mix_pkg;
   // Address of the master-volume register on the shared write port
   localparam logic [4:0] MIX_VOL_ADDR_DEF = 5'h18;
   localparam int MIX_PERIOD_DEF = 255;

   // Clip a wide unsigned value to a maximum
   function automatic int unsigned mix_clip(input int unsigned val, input int unsigned lim);
      return (val > lim) ? lim : val;
   endfunction
endpackage

// File: rtl/mix_vol_reg.sv
module mix_vol_reg #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int VOL_W  = 4,
   parameter logic [ADDR_W-1:0] VOL_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [VOL_W-1:0]  vol_q
);
   logic hit;
   assign hit = we && (addr == VOL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vol_q <= '0;
      else if (hit) vol_q <= wdata[VOL_W-1:0];
   end
endmodule

// File: rtl/mix_scaler.sv
module mix_scaler #(
   parameter int NUM_VOICES = 3,
   parameter int SAMPLE_W   = 8,
   parameter int VOL_W      = 4,
   parameter int VOL_MAX    = 15,
   parameter bit SATURATE   = 1'b1
) (
   input  logic [NUM_VOICES*SAMPLE_W-1:0] samples,
   input  logic [VOL_W-1:0]               vol,
   output logic [SAMPLE_W-1:0]            duty
);
   localparam int SUM_MAX = NUM_VOICES * ((1 << SAMPLE_W) - 1);
   localparam int SUM_W   = $clog2(SUM_MAX + 1);
   localparam int PROD_W  = SUM_W + VOL_W;
   localparam logic [PROD_W-1:0] DUTY_MAX = PROD_W'((1 << SAMPLE_W) - 1);
   localparam logic [PROD_W-1:0] DIVISOR  = PROD_W'(VOL_MAX);

   logic [SUM_W-1:0] part [NUM_VOICES+1];
   assign part[0] = '0;

   for (genvar k = 0; k < NUM_VOICES; k++) begin : g_sum
      assign part[k+1] = part[k] + SUM_W'(samples[k*SAMPLE_W +: SAMPLE_W]);
   end

   logic [PROD_W-1:0] prod, quot;
   assign prod = PROD_W'(part[NUM_VOICES]) * PROD_W'(vol);
   assign quot = prod / DIVISOR;

   if (SATURATE) begin : g_sat
      assign duty = (quot > DUTY_MAX) ? SAMPLE_W'(DUTY_MAX) : quot[SAMPLE_W-1:0];
   end else begin : g_wrap
      assign duty = quot[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/mix_pwm_gen.sv
module mix_pwm_gen #(
   parameter int DUTY_W = 8,
   parameter int PERIOD = 255
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DUTY_W-1:0]         duty_next,
   output logic [$clog2(PERIOD)-1:0] cnt_q,
   output logic [DUTY_W-1:0]         duty_q,
   output logic                      pwm
);
   localparam int CNT_W = $clog2(PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic wrap;
   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= '0;
      end else if (wrap) begin
         cnt_q  <= '0;
         duty_q <= duty_next;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // Compare in a common width so that any counter width works
   assign pwm = (32'(cnt_q) < 32'(duty_q));
endmodule

// File: rtl/mix_pwm_top.sv
module mix_pwm_top
   import mix_pkg::*;
#(
   parameter int NUM_VOICES = 3,
   parameter int SAMPLE_W   = 8,
   parameter int VOL_W      = 4,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int PERIOD     = MIX_PERIOD_DEF,
   parameter logic [ADDR_W-1:0] VOL_ADDR = ADDR_W'(MIX_VOL_ADDR_DEF),
   parameter bit SATURATE   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_VOICES*SAMPLE_W-1:0] voice_samples,
   input  logic                           reg_we,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic [DATA_W-1:0]              reg_wdata,
   output logic                           pwm_out
);
   localparam int VOL_MAX = (1 << VOL_W) - 1;
   localparam int CNT_W   = $clog2(PERIOD);

   if (PERIOD < 2 || PERIOD > (1 << SAMPLE_W)) begin : g_bad_period
      $error("mix_pwm_top: PERIOD must lie in 2..2**SAMPLE_W");
   end
   if (VOL_W < 1 || VOL_W > DATA_W) begin : g_bad_vol
      $error("mix_pwm_top: VOL_W must lie in 1..DATA_W");
   end
   if (NUM_VOICES < 1) begin : g_bad_voices
      $error("mix_pwm_top: at least one voice required");
   end

   logic [VOL_W-1:0]    vol_w;
   logic [SAMPLE_W-1:0] duty_next_w;
   logic [SAMPLE_W-1:0] duty_w;
   logic [CNT_W-1:0]    cnt_w;

   mix_vol_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VOL_W(VOL_W), .VOL_ADDR(VOL_ADDR)
   ) u_vol (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .vol_q(vol_w)
   );

   mix_scaler #(
      .NUM_VOICES(NUM_VOICES), .SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W),
      .VOL_MAX(VOL_MAX), .SATURATE(SATURATE)
   ) u_scale (
      .samples(voice_samples), .vol(vol_w), .duty(duty_next_w)
   );

   mix_pwm_gen #(
      .DUTY_W(SAMPLE_W), .PERIOD(PERIOD)
   ) u_pwm (
      .clk(clk), .rst_n(rst_n), .duty_next(duty_next_w),
      .cnt_q(cnt_w), .duty_q(duty_w), .pwm(pwm_out)
   );
endmodule

// File: rtl/mix_pwm_checker.sv
module mix_pwm_checker #(
   parameter int SAMPLE_W = 8,
   parameter int VOL_W    = 4,
   parameter int ADDR_W   = 5,
   parameter int PERIOD   = 255,
   parameter logic [ADDR_W-1:0] VOL_ADDR = '0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_we,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic                      pwm_out,
   input logic [VOL_W-1:0]          vol_w,
   input logic [SAMPLE_W-1:0]       duty_w,
   input logic [$clog2(PERIOD)-1:0] cnt_w
);
   localparam int CNT_W = $clog2(PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_w) < PERIOD);

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w != LAST) |=> (cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

   a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w != '0) |-> $stable(duty_w));

   a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_w == '0) |-> !pwm_out);

   a_r9_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_w == '1) |-> pwm_out);

   a_r9_mute_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w == LAST && vol_w == '0) |=> (duty_w == '0));

   a_r8_vol_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == VOL_ADDR) |=> $stable(vol_w));
endmodule

bind mix_pwm_top mix_pwm_checker #(
   .SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W), .ADDR_W(ADDR_W),
   .PERIOD(PERIOD), .VOL_ADDR(VOL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .pwm_out(pwm_out), .vol_w(vol_w), .duty_w(duty_w), .cnt_w(cnt_w)
);

// File: tb/mix_pwm_top_test.sv
module mix_pwm_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] vs = '0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wd = '0;
   logic        pwm;

   int tests = 0, fails = 0;
   string req = "R1";
   int m_cnt = 0, m_duty = 0, m_vol = 0;

   mix_pwm_top uut (
      .clk(clk), .rst_n(rst_n), .voice_samples(vs), .reg_we(we),
      .reg_addr(addr), .reg_wdata(wd), .pwm_out(pwm)
   );

   always #4 clk = ~clk;

   // Behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_duty = 0; m_vol = 0;
      end else begin
         if (m_cnt == 254) begin
            int s;
            s = int'(vs[7:0]) + int'(vs[15:8]) + int'(vs[23:16]);
            m_duty = (s * m_vol) / 15;
            if (m_duty > 255) m_duty = 255;
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
         if (we && addr == 5'h18) m_vol = int'(wd) % 16;
      end
   end

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) chk(pwm === (m_cnt < m_duty), req, int'(pwm), int'(m_cnt < m_duty));
   end

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic set_v(input int a, input int b, input int c);
      vs = {8'(c), 8'(b), 8'(a)};
   endtask

   task automatic next_start();
      do @(negedge clk); while (m_cnt != 0);
   endtask

   // Count high cycles over one period starting at the current negedge (counter 0)
   task automatic measure(input int exp, input string r);
      int h = 0;
      for (int i = 0; i < 255; i++) begin
         if (pwm === 1'b1) h++;
         @(negedge clk);
      end
      chk(h == exp, r, h, exp);
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(pwm === 1'b0, "R1", int'(pwm), 0);
      set_v(50, 50, 50);
      rst_n = 1'b1;
      measure(0, "R1");           // first period after release is all low

      // R7/R4: volume write, normal mix
      req = "R4";
      wr(5'h18, 8'h0F);
      set_v(10, 20, 30);
      next_start(); measure(60, "R4");

      // R2/R3: different pattern
      req = "R3";
      wr(5'h18, 8'h08);
      set_v(100, 100, 100);
      next_start(); measure(160, "R3");
      measure(160, "R2");          // back-to-back periods keep 255-clock spacing

      // R5/R9: saturation gives constant high
      req = "R5";
      wr(5'h18, 8'h0F);
      set_v(255, 255, 255);
      next_start(); measure(255, "R5");
      measure(255, "R9");

      // R9: volume zero mutes
      req = "R9";
      wr(5'h18, 8'h00);
      next_start(); measure(0, "R9");

      // R8: other addresses leave volume alone
      req = "R8";
      wr(5'h18, 8'h05);
      set_v(90, 90, 90);
      wr(5'h15, 8'h0F); wr(5'h16, 8'h0F); wr(5'h17, 8'h0F);
      wr(5'h00, 8'h0F); wr(5'h1F, 8'h0F); wr(5'h10, 8'h0F);
      next_start(); measure(90, "R8");

      // R7: upper data bits ignored (0xA7 -> volume 7)
      req = "R7";
      wr(5'h18, 8'hA7);
      next_start(); measure(126, "R7");

      // R6: mid-period changes wait for the next period
      req = "R6";
      wr(5'h18, 8'h0F);
      set_v(10, 20, 30);
      next_start();                // duty 60 latched
      repeat (10) @(negedge clk);
      set_v(200, 200, 200);
      wr(5'h18, 8'h03);
      do @(negedge clk); while (m_cnt != 0);
      measure(120, "R6");          // 600*3/15

      // R6: volume write on the wrap edge
      wr(5'h18, 8'h0F);
      set_v(30, 30, 30);
      next_start();                // latches 90 at volume 15
      do @(negedge clk); while (m_cnt != 254);
      we = 1'b1; addr = 5'h18; wd = 8'h05;
      @(negedge clk); we = 1'b0;
      measure(90, "R6");           // old volume used at the coinciding edge
      measure(30, "R6");           // new volume one period later

      // R1: reset mid-period returns the output low
      req = "R1";
      @(negedge clk); rst_n = 1'b0;
      #1 chk(pwm === 1'b0, "R1", int'(pwm), 0);
      @(negedge clk); rst_n = 1'b1;
      measure(0, "R1");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule